// File: doc/BRIEF.md
# Multilevel Noise-Shaping Modulator with Triangular Dither

This block converts an oversampled stream of twos-complement audio words into a 17-level code that drives a multi-element DAC. The stream arrives at nominally 128 times the audio sample rate. Each word is marked by a one-cycle strobe. Words of 16 bits are left-aligned in the 18-bit input, so both widths share one scale. One quantization step is 2^14 input units, and level code c stands for the value (c - 8) × 2^14.

The block holds a second-order error-feedback loop, a rounding quantizer, and a dither source. The loop keeps the last two quantization errors. Each stored error is limited to ±1 step, so the loop stays bounded and recovers after full-scale input. The dither source adds two uniform values from two separate maximal-length LFSRs, which gives a triangular distribution. This sum is added to the signal just before the quantizer. A control input switches the dither off, so the quantizer output can be compared exactly against the input.

Top module: `sdm_mod`

## Requirements
- R1: Reset is synchronous and active high. It sets the output code to 8, clears both stored errors and reloads both LFSRs with their nonzero seeds, so any input sequence after any reset produces the same code sequence. Reset wins over a strobe in the same cycle.
- R2: The output code always lies in 0..16. Code c represents (c - 8) × 2^14 input units.
- R3: The code register changes only on a strobe cycle, and the new code is visible after that rising edge. Without a strobe it holds, whatever the input word does.
- R4: With dither off, a constant input that is an integer k of steps gives code 8 + k on every strobe from reset. Input 0 gives 8, input 3 × 2^14 gives 11, and input -2^17 gives 0.
- R5: With dither off and |x| ≤ 5 steps held constant from reset, the running sum of level values over N strobes stays within one step (2^14) of N·x.
- R6: Dither is the sum of two values, each uniform in [-2^13, 2^13 - 1]. Each value comes from its own maximal-length LFSR, and both LFSRs advance once per strobe only. With dither on and zero input, every code is in 5..11 and not all codes are 8.
- R7: With dither on and |x| ≤ 5 steps held constant from reset, the sum of level values over 512 strobes stays within 512 × 2^14 / 8 of 512·x.
- R8: Each stored error is limited to ±1 step. At input 2^17 - 1 with dither off, every code is in 13..16. When the input then returns to a constant in-range value, the running sum stays within 3 steps of N·x without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | One-cycle strobe marking a new oversampled word |
| in_smp | input | 18 | Twos-complement audio word (16-bit words left-aligned) |
| dith_en | input | 1 | 1 adds triangular dither ahead of the quantizer |
| lvl_code | output | 5 | Unsigned level code 0..16, 8 is zero |

## Verification
A reset and a sample strobe can fall in the same cycle. When they do, the reset must discard the loop update and also keep the LFSRs from advancing. To provoke this, the bench records a dithered code sequence, then resets with the strobe held high and an off-zero input word. It then replays the same inputs with different idle gaps. The result is judged correct only if the code reads 8 after the reset and the replayed sequence matches the first one code for code.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    localparam int DATA_W_DEF   = 18;
    localparam int HALF_LEV_DEF = 8;

    typedef enum logic [1:0] {
        CLIP_NONE,
        CLIP_HI,
        CLIP_LO
    } clip_e;

    // Feedback tap mask (bit i set = stage i+1 tapped) for maximal-length
    // Fibonacci shift registers of the supported widths.
    function automatic logic [31:0] lfsr_taps(input int w);
        logic [31:0] m;
        m = '0;
        case (w)
            15: begin m[14] = 1'b1; m[13] = 1'b1; end
            16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
            17: begin m[16] = 1'b1; m[13] = 1'b1; end
            18: begin m[17] = 1'b1; m[10] = 1'b1; end
            20: begin m[19] = 1'b1; m[16] = 1'b1; end
            default: begin m[16] = 1'b1; m[13] = 1'b1; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sdm_lfsr.sv
module sdm_lfsr #(
    parameter int          W    = 17,
    parameter logic [31:0] SEED = 32'h0000_ACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state
);

    localparam logic [31:0]  TAPS_ALL = sdm_pkg::lfsr_taps(W);
    localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];
    localparam logic [W-1:0] SEED_W   = SEED[W-1:0];

    logic fb;

    always_comb fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED_W;
        end else if (adv) begin
            state <= {state[W-2:0], fb};
        end
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst) state != '0); // R1

endmodule

// File: rtl/sdm_tpdf_dither.sv
module sdm_tpdf_dither #(
    parameter int          DW     = 14,
    parameter int          A_W    = 17,
    parameter int          B_W    = 18,
    parameter logic [31:0] SEED_A = 32'h0000_ACE1,
    parameter logic [31:0] SEED_B = 32'h0001_3579
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic                 en,
    output logic signed [DW:0]   dith
);

    localparam int NSRC = 2;

    logic        [DW-1:0] raw [NSRC];
    logic signed [DW-1:0] uni [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int          GW = (g == 0) ? A_W : B_W;
        localparam logic [31:0] GS = (g == 0) ? SEED_A : SEED_B;
        logic [GW-1:0] st;

        sdm_lfsr #(.W(GW), .SEED(GS)) u_src (
            .clk   (clk),
            .rst   (rst),
            .adv   (adv),
            .state (st)
        );

        // Offset binary to twos complement: uniform in [-2^(DW-1), 2^(DW-1)-1]
        assign raw[g] = st[DW-1:0];
        assign uni[g] = {~raw[g][DW-1], raw[g][DW-2:0]};
    end

    always_comb begin
        if (en) begin
            dith = {uni[0][DW-1], uni[0]} + {uni[1][DW-1], uni[1]};
        end else begin
            dith = '0;
        end
    end

    AST_DITHER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(en) -> $stable(dith))); // R6

endmodule

// File: rtl/sdm_quant.sv
module sdm_quant #(
    parameter int ACC_W    = 20,
    parameter int STEP_SH  = 14,
    parameter int HALF_LEV = 8,
    parameter int CODE_W   = 5
) (
    input  logic signed [ACC_W-1:0] w,
    output logic        [CODE_W-1:0] code,
    output logic signed [ACC_W-1:0] lvl,
    output sdm_pkg::clip_e          clip
);

    localparam logic signed [ACC_W:0] HALF_STEP = (ACC_W+1)'(2**(STEP_SH-1));
    localparam logic signed [ACC_W:0] LIM_HI    = (ACC_W+1)'(HALF_LEV);
    localparam logic signed [ACC_W:0] LIM_LO    = -LIM_HI;

    logic signed [ACC_W:0] biased;
    logic signed [ACC_W:0] rnd;
    logic signed [ACC_W:0] sel;

    always_comb begin
        biased = {w[ACC_W-1], w} + HALF_STEP;   // round half up
        rnd    = biased >>> STEP_SH;
        if (rnd > LIM_HI) begin
            sel  = LIM_HI;
            clip = sdm_pkg::CLIP_HI;
        end else if (rnd < LIM_LO) begin
            sel  = LIM_LO;
            clip = sdm_pkg::CLIP_LO;
        end else begin
            sel  = rnd;
            clip = sdm_pkg::CLIP_NONE;
        end
        code = CODE_W'(sel + LIM_HI);
        lvl  = ACC_W'(sel <<< STEP_SH);
    end

endmodule

// File: rtl/sdm_mod.sv
module sdm_mod #(
    parameter int          DATA_W   = sdm_pkg::DATA_W_DEF,
    parameter int          HALF_LEV = sdm_pkg::HALF_LEV_DEF,
    parameter int          LFSR_A_W = 17,
    parameter int          LFSR_B_W = 18,
    parameter logic [31:0] SEED_A   = 32'h0000_ACE1,
    parameter logic [31:0] SEED_B   = 32'h0001_3579
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_vld,
    input  logic signed [DATA_W-1:0]              in_smp,
    input  logic                                  dith_en,
    output logic [$clog2(2*HALF_LEV+1)-1:0]       lvl_code
);

    localparam int NLEV    = 2 * HALF_LEV + 1;
    localparam int CODE_W  = $clog2(NLEV);
    localparam int STEP_SH = DATA_W - 1 - $clog2(HALF_LEV);
    localparam int ACC_W   = DATA_W + 2;
    localparam int WIDE_W  = ACC_W + 3;

    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        acc_t e1;
        acc_t e2;
    } hist_t;

    localparam wide_t ACC_MAX = WIDE_W'(2**(ACC_W-1) - 1);
    localparam wide_t ACC_MIN = -ACC_MAX - 1;
    localparam wide_t ERR_LIM = WIDE_W'(2**STEP_SH);
    localparam acc_t  HALF_Q  = ACC_W'(2**(STEP_SH-1));
    localparam logic signed [DATA_W-1:0] FS_POS = DATA_W'(2**(DATA_W-1) - 1);

    function automatic acc_t clamp(input wide_t v, input wide_t lo, input wide_t hi);
        if (v > hi) return acc_t'(hi);
        if (v < lo) return acc_t'(lo);
        return acc_t'(v);
    endfunction

    hist_t                hist;
    logic signed [STEP_SH:0] dith;
    wide_t                u_w, w_w, err_w;
    acc_t                 u_s, w_s, v_q, err_s;
    logic [CODE_W-1:0]    code_n;
    sdm_pkg::clip_e       clip;

    sdm_tpdf_dither #(
        .DW     (STEP_SH),
        .A_W    (LFSR_A_W),
        .B_W    (LFSR_B_W),
        .SEED_A (SEED_A),
        .SEED_B (SEED_B)
    ) u_dith (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_vld),
        .en   (dith_en),
        .dith (dith)
    );

    // Second-order error feedback: u = x - 2e[n-1] + e[n-2]
    always_comb begin
        u_w = wide_t'(in_smp) - (wide_t'(hist.e1) <<< 1) + wide_t'(hist.e2);
        u_s = clamp(u_w, ACC_MIN, ACC_MAX);
        w_w = wide_t'(u_s) + wide_t'(dith);
        w_s = clamp(w_w, ACC_MIN, ACC_MAX);
    end

    sdm_quant #(
        .ACC_W    (ACC_W),
        .STEP_SH  (STEP_SH),
        .HALF_LEV (HALF_LEV),
        .CODE_W   (CODE_W)
    ) u_quant (
        .w    (w_s),
        .code (code_n),
        .lvl  (v_q),
        .clip (clip)
    );

    always_comb begin
        err_w = wide_t'(v_q) - wide_t'(w_s);
        err_s = clamp(err_w, -ERR_LIM, ERR_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            lvl_code <= CODE_W'(HALF_LEV);
        end else if (in_vld) begin
            hist.e2  <= hist.e1;
            hist.e1  <= err_s;
            lvl_code <= code_n;
        end
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        lvl_code <= CODE_W'(NLEV - 1)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(lvl_code)); // R3
    AST_RESET_MID: assert property (@(posedge clk)
        rst |=> lvl_code == CODE_W'(HALF_LEV)); // R1
    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
        (in_vld && clip == sdm_pkg::CLIP_NONE) |=> (hist.e1 <= HALF_Q && hist.e1 >= -HALF_Q)); // R5
    AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !dith_en && in_smp == FS_POS) |=> lvl_code >= CODE_W'(NLEV - 4)); // R8

endmodule

// File: tb/sdm_mod_tb.sv
module sdm_mod_tb;

    localparam int  STEP = 1 << 14;
    localparam int  MID  = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_vld = 1'b0;
    logic signed [17:0] in_smp = '0;
    logic               dith_en = 1'b0;
    logic [4:0]         lvl_code;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    int  seq_x [40];
    int  seq_c [40];

    always #5 clk = ~clk;

    sdm_mod u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_smp   (in_smp),
        .dith_en  (dith_en),
        .lvl_code (lvl_code)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit with_vld);
        @(negedge clk);
        rst    = 1'b1;
        in_vld = with_vld;
        in_smp = 18'sd5 * 18'(STEP);
        repeat (2) @(negedge clk);
        rst    = 1'b0;
        in_vld = 1'b0;
        check(lvl_code == 5'(MID), "R1 reset code", lvl_code, MID);
    endtask

    // Applies one strobe at a negedge, samples the code one edge later,
    // then idles for gap cycles with a scrambled input word.
    task automatic push(input int x, input int gap, output int c);
        in_smp = 18'(x);
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        c = int'(lvl_code);
        check(c >= 0 && c <= 16, "R2 code range", c, 16);
        for (int k = 0; k < gap; k++) begin
            in_smp = 18'($urandom);
            @(negedge clk);
            check(int'(lvl_code) == c, "R3 hold without strobe", lvl_code, c);
        end
    endtask

    task automatic mean_run(input int x, input int n, input longint tol, input string req);
        longint acc = 0;
        int c;
        for (int i = 0; i < n; i++) begin
            push(x, $urandom_range(2), c);
            acc += longint'(c - MID) * STEP;
        end
        check((acc - longint'(n) * x) <= tol && (acc - longint'(n) * x) >= -tol,
              req, acc - longint'(n) * x, 0);
    endtask

    initial begin
        int c;
        int off_mid;
        void'($urandom(32'd7919));

        // R1: reset state
        do_reset(1'b0);

        // R4: exact constant inputs with dither off
        dith_en = 1'b0;
        for (int i = 0; i < 48; i++) begin
            push(0, i % 3, c);
            check(c == 8, "R4 zero input", c, 8);
        end
        do_reset(1'b0);
        for (int i = 0; i < 32; i++) begin
            push(3 * STEP, 0, c);
            check(c == 11, "R4 three steps", c, 11);
        end
        do_reset(1'b0);
        for (int i = 0; i < 32; i++) begin
            push(-(1 << 17), 1, c);
            check(c == 0, "R4 negative full scale", c, 0);
        end

        // R5: running sum tracks the input, dither off
        for (int t = 0; t < 6; t++) begin
            do_reset(1'b0);
            mean_run(int'($urandom_range(10 * STEP)) - 5 * STEP, 256, STEP, "R5 mean no dither");
        end

        // R6: dithered zero input stays near mid and is not constant
        do_reset(1'b0);
        dith_en = 1'b1;
        off_mid = 0;
        for (int i = 0; i < 128; i++) begin
            push(0, $urandom_range(1), c);
            check(c >= 5 && c <= 11, "R6 dither span", c, 8);
            if (c != 8) off_mid++;
        end
        check(off_mid > 0, "R6 dither active", off_mid, 1);

        // R7: running sum with dither on
        for (int t = 0; t < 4; t++) begin
            do_reset(1'b0);
            mean_run(int'($urandom_range(10 * STEP)) - 5 * STEP, 512,
                     longint'(512) * STEP / 8, "R7 mean with dither");
        end

        // R1/R6: reseed and reset-over-strobe give identical replay
        for (int i = 0; i < 40; i++) seq_x[i] = int'($urandom_range(8 * STEP)) - 4 * STEP;
        do_reset(1'b0);
        for (int i = 0; i < 40; i++) push(seq_x[i], 0, seq_c[i]);
        do_reset(1'b1);
        for (int i = 0; i < 40; i++) begin
            push(seq_x[i], 1 + (i % 2), c);
            check(c == seq_c[i], "R1 replay after reset with strobe", c, seq_c[i]);
        end

        // R8: positive full scale and recovery without reset
        do_reset(1'b0);
        dith_en = 1'b0;
        for (int i = 0; i < 128; i++) begin
            push((1 << 17) - 1, i % 2, c);
            check(c >= 13 && c <= 16, "R8 full scale codes", c, 16);
        end
        mean_run(2 * STEP, 256, 3 * STEP, "R8 recovery mean");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule